// File: doc/BRIEF.md
# Network Interface Flit Packetizer

This block is the transmit half of a core-side network interface, with a small receive path beside it. A core issues a store command that names a destination node and a word count. The block then takes that many payload words from a separate word stream. It turns the command into a packet of flits for the local router: one header flit, zero or more body flits, and one end flit. Every flit carries a two-bit kind code, the destination node, this node's own identifier and a payload field. The header payload holds this node's running packet number and the packet's word count. The command side, the word stream and the router side each use a valid/ready handshake. The router side is a full register stage, so a low router ready freezes the offered flit and loses nothing.

On the receive side, flits from the router are decoded. Body and end flits addressed to this node have their payload written to the attached memory. The write address is built from the sending node and the word's position within its packet. Header flits only restart the position count. Flits for other nodes and flits with the invalid kind code are dropped.

Top module: `ni_pktzr`

## Requirements
- R1: A header flit has kind code 2'b01, carries the command's destination, the source field equal to parameter MY_ID, packet number in payload bits [15:8], word count in bits [7:0] and zero in the payload bits above 15.
- R2: A command with `cmd_len` = N-1 yields exactly N+1 flits in this order: the header, then N-1 body flits of kind 2'b10 carrying words 0..N-2 in arrival order, then one end flit of kind 2'b11 carrying the last word. Body and end flits carry the same destination and source as the header.
- R3: A one-word command (`cmd_len` = 0) yields a header followed directly by an end flit carrying that word, with no body flit.
- R4: The packet number is 0 in the first header after reset and rises by one in each later header, wrapping from 255 to 0.
- R5: While `flit_valid` is high and `flit_ready` is low, the next cycle keeps `flit_valid` high and `flit_data` unchanged.
- R6: Under any pattern of `flit_ready` and gaps in `wd_valid`, every accepted payload word leaves exactly once, in order, and no flit is dropped or repeated.
- R7: `cmd_ready` is low from the cycle after a command is accepted until the packet's end flit has been taken into the output stage.
- R8: During and right after reset, `flit_valid` and `mem_we` are low and `cmd_ready` is high.
- R9: A received body or end flit whose destination equals MY_ID raises `mem_we` in the next cycle. The write carries the flit payload at address {source field, index}. The index is 0 for the first such flit after a header and rises by one per write.
- R10: A received header flit, a flit of kind 2'b00 and a flit whose destination differs from MY_ID cause no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Store command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_dest | input | NODE_W | Destination node of the command |
| cmd_len | input | LEN_W | Word count minus one |
| wd_valid | input | 1 | Payload word offered |
| wd_ready | output | 1 | Payload word taken |
| wd_data | input | DATA_W | Payload word |
| flit_valid | output | 1 | Flit offered to the router |
| flit_ready | input | 1 | Router takes the flit |
| flit_data | output | FLIT_W | Flit {kind, dest, src, payload} |
| rx_valid | input | 1 | Received flit present |
| rx_flit | input | FLIT_W | Received flit |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | NODE_W+LEN_W | Write address {source, index} |
| mem_wdata | output | DATA_W | Write data |

## Verification
Directed packets of one word and of the maximum length separate the end-only path from the full header/body/end sequence. Several hundred random-length packets under random router backpressure and random gaps in the word stream tell ordering, loss and duplication faults apart from format faults. That run also carries the packet number across its wrap from 255 to 0. On the receive side, a directed flit list mixes matching body and end flits with headers, foreign destinations and the invalid kind code. This shows apart an index that fails to restart or advance, and filtering that fails to drop what it should.

// File: rtl/ni_pkg.sv
package ni_pkg;
  localparam int PNUM_W = 8;

  typedef enum logic [1:0] {
    FK_NONE = 2'b00,
    FK_HEAD = 2'b01,
    FK_BODY = 2'b10,
    FK_END  = 2'b11
  } flit_kind_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'b00,
    TX_HEAD = 2'b01,
    TX_DATA = 2'b10
  } tx_state_e;

  // header payload: packet number over word count
  function automatic logic [15:0] hdr_info(logic [PNUM_W-1:0] pnum, logic [7:0] cnt);
    return {pnum, cnt};
  endfunction

  // word count from the minus-one length field
  function automatic logic [7:0] words_of(logic [7:0] len_m1);
    return len_m1 + 8'd1;
  endfunction
endpackage

// File: rtl/ni_tx_seq.sv
module ni_tx_seq
  import ni_pkg::*;
#(
  parameter int NODE_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 16,
  parameter int MY_ID   = 5,
  parameter int LEN_W   = $clog2(MAX_LEN),
  parameter int FLIT_W  = 2 + 2*NODE_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [NODE_W-1:0] cmd_dest,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  input  logic              can_load,
  output logic              gen_vld,
  output logic [FLIT_W-1:0] gen_flit,
  output logic              ev_hdr,
  output logic [PNUM_W-1:0] pnum
);
  localparam int CNT_W = LEN_W + 1;

  tx_state_e         state_q;
  logic [NODE_W-1:0] dest_q;
  logic [CNT_W-1:0]  rem_q;
  logic [PNUM_W-1:0] pnum_q;
  logic              word_fire;
  logic              last_word;

  function automatic logic [FLIT_W-1:0] pack(flit_kind_e k, logic [NODE_W-1:0] d,
                                             logic [DATA_W-1:0] p);
    return {k, d, NODE_W'(MY_ID), p};
  endfunction

  assign cmd_ready = (state_q == TX_IDLE);
  assign last_word = (rem_q == CNT_W'(1));
  assign wd_ready  = (state_q == TX_DATA) && can_load;
  assign word_fire = wd_ready && wd_valid;
  assign ev_hdr    = (state_q == TX_HEAD) && can_load;
  assign pnum      = pnum_q;

  always_comb begin
    gen_vld  = 1'b0;
    gen_flit = '0;
    case (state_q)
      TX_HEAD: begin
        gen_vld  = 1'b1;
        gen_flit = pack(FK_HEAD, dest_q, DATA_W'(hdr_info(pnum_q, 8'(rem_q))));
      end
      TX_DATA: begin
        gen_vld  = wd_valid;
        gen_flit = pack(last_word ? FK_END : FK_BODY, dest_q, wd_data);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      dest_q  <= '0;
      rem_q   <= '0;
      pnum_q  <= '0;
    end else begin
      case (state_q)
        TX_IDLE: if (cmd_valid) begin
          dest_q  <= cmd_dest;
          rem_q   <= CNT_W'(words_of(8'(cmd_len)));
          state_q <= TX_HEAD;
        end
        TX_HEAD: if (can_load) begin
          pnum_q  <= pnum_q + 1'b1;
          state_q <= TX_DATA;
        end
        TX_DATA: if (word_fire) begin
          rem_q <= rem_q - 1'b1;
          if (last_word) state_q <= TX_IDLE;
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ni_flit_hold.sv
module ni_flit_hold #(
  parameter int FLIT_W = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              can_load,
  output logic              out_vld,
  input  logic              out_ready,
  output logic [FLIT_W-1:0] out_flit
);
  assign can_load = !out_vld || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_flit <= '0;
    end else if (can_load) begin
      out_vld <= in_vld;
      if (in_vld) out_flit <= in_flit;
    end
  end
endmodule

// File: rtl/ni_rx_strip.sv
module ni_rx_strip
  import ni_pkg::*;
#(
  parameter int NODE_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MY_ID   = 5,
  parameter int LEN_W   = 4,
  parameter int FLIT_W  = 2 + 2*NODE_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic [FLIT_W-1:0]       rx_flit,
  output logic                    mem_we,
  output logic [NODE_W+LEN_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata
);
  flit_kind_e        kind;
  logic [NODE_W-1:0] f_dest;
  logic [NODE_W-1:0] f_src;
  logic [DATA_W-1:0] f_pay;
  logic              for_me;
  logic              is_data;
  logic              is_head;
  logic [LEN_W-1:0]  idx_q;

  assign kind    = flit_kind_e'(rx_flit[FLIT_W-1 -: 2]);
  assign f_dest  = rx_flit[FLIT_W-3 -: NODE_W];
  assign f_src   = rx_flit[DATA_W +: NODE_W];
  assign f_pay   = rx_flit[DATA_W-1:0];
  assign for_me  = rx_valid && (f_dest == NODE_W'(MY_ID));
  assign is_data = for_me && (kind == FK_BODY || kind == FK_END);
  assign is_head = for_me && (kind == FK_HEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      idx_q     <= '0;
    end else begin
      mem_we <= is_data;
      if (is_data) begin
        mem_addr  <= {f_src, idx_q};
        mem_wdata <= f_pay;
        idx_q     <= idx_q + 1'b1;
      end else if (is_head) begin
        idx_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ni_pktzr.sv
module ni_pktzr
  import ni_pkg::*;
#(
  parameter int NODE_W  = 4,
  parameter int DATA_W  = 32,
  parameter int MAX_LEN = 16,
  parameter int MY_ID   = 5,
  parameter int LEN_W   = $clog2(MAX_LEN),
  parameter int FLIT_W  = 2 + 2*NODE_W + DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [NODE_W-1:0]       cmd_dest,
  input  logic [LEN_W-1:0]        cmd_len,
  input  logic                    wd_valid,
  output logic                    wd_ready,
  input  logic [DATA_W-1:0]       wd_data,
  output logic                    flit_valid,
  input  logic                    flit_ready,
  output logic [FLIT_W-1:0]       flit_data,
  input  logic                    rx_valid,
  input  logic [FLIT_W-1:0]       rx_flit,
  output logic                    mem_we,
  output logic [NODE_W+LEN_W-1:0] mem_addr,
  output logic [DATA_W-1:0]       mem_wdata
);
  logic              can_load;
  logic              gen_vld;
  logic [FLIT_W-1:0] gen_flit;
  logic              ev_hdr;
  logic [PNUM_W-1:0] pnum;

  ni_tx_seq #(
    .NODE_W(NODE_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN),
    .MY_ID(MY_ID), .LEN_W(LEN_W), .FLIT_W(FLIT_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_len(cmd_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .can_load(can_load), .gen_vld(gen_vld), .gen_flit(gen_flit),
    .ev_hdr(ev_hdr), .pnum(pnum)
  );

  ni_flit_hold #(.FLIT_W(FLIT_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_vld(gen_vld), .in_flit(gen_flit), .can_load(can_load),
    .out_vld(flit_valid), .out_ready(flit_ready), .out_flit(flit_data)
  );

  ni_rx_strip #(
    .NODE_W(NODE_W), .DATA_W(DATA_W), .MY_ID(MY_ID),
    .LEN_W(LEN_W), .FLIT_W(FLIT_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_flit(rx_flit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/ni_pktzr_chk.sv
module ni_pktzr_chk
  import ni_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int DATA_W = 32,
  parameter int MY_ID  = 5,
  parameter int FLIT_W = 2 + 2*NODE_W + DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              flit_valid,
  input logic              flit_ready,
  input logic [FLIT_W-1:0] flit_data,
  input logic              rx_valid,
  input logic [FLIT_W-1:0] rx_flit,
  input logic              mem_we,
  input logic              ev_hdr,
  input logic [PNUM_W-1:0] pnum
);
  logic [1:0] out_kind;
  logic [1:0] rx_kind;
  assign out_kind = flit_data[FLIT_W-1 -: 2];
  assign rx_kind  = rx_flit[FLIT_W-1 -: 2];

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid && !flit_ready |=> flit_valid && $stable(flit_data));

  a_r2_kind_never_none: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> out_kind != 2'b00);

  a_r1_src_is_self: assert property (@(posedge clk) disable iff (!rst_n)
    flit_valid |-> flit_data[DATA_W +: NODE_W] == NODE_W'(MY_ID));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);

  a_r4_pnum_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hdr |=> pnum == $past(pnum) + 1'b1);

  a_r4_pnum_still: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_hdr |=> $stable(pnum));

  a_r10_drop_none_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_kind == 2'b00 |=> !mem_we);

  a_r9_write_needs_flit: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !mem_we);
endmodule

bind ni_pktzr ni_pktzr_chk #(
  .NODE_W(NODE_W), .DATA_W(DATA_W), .MY_ID(MY_ID), .FLIT_W(FLIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data),
  .rx_valid(rx_valid), .rx_flit(rx_flit), .mem_we(mem_we),
  .ev_hdr(ev_hdr), .pnum(pnum)
);

// File: tb/sim_ni_pktzr.sv
module sim_ni_pktzr;
  localparam int NODE_W  = 4;
  localparam int DATA_W  = 32;
  localparam int MAX_LEN = 16;
  localparam int MY_ID   = 5;
  localparam int LEN_W   = 4;
  localparam int FLIT_W  = 2 + 2*NODE_W + DATA_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [NODE_W-1:0] cmd_dest = '0;
  logic [LEN_W-1:0]  cmd_len = '0;
  logic wd_valid = 1'b0;
  logic wd_ready;
  logic [DATA_W-1:0] wd_data = '0;
  logic flit_valid;
  logic flit_ready = 1'b0;
  logic [FLIT_W-1:0] flit_data;
  logic rx_valid = 1'b0;
  logic [FLIT_W-1:0] rx_flit = '0;
  logic mem_we;
  logic [NODE_W+LEN_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  int tests = 0;
  int fails = 0;
  int rdy_pct = 100;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_pnum = 8'd0;
  logic [FLIT_W-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  ni_pktzr u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dest(cmd_dest), .cmd_len(cmd_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .flit_valid(flit_valid), .flit_ready(flit_ready), .flit_data(flit_data),
    .rx_valid(rx_valid), .rx_flit(rx_flit),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  function automatic logic [FLIT_W-1:0] mk_flit(logic [1:0] k, logic [NODE_W-1:0] d,
                                                logic [NODE_W-1:0] s, logic [DATA_W-1:0] p);
    return {k, d, s, p};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // router side: random ready, compare each transferred flit, stall hold
  initial begin
    bit prev_stall = 1'b0;
    logic [FLIT_W-1:0] prev_flit = '0;
    forever begin
      @(negedge clk);
      flit_ready = (($urandom % 100) < rdy_pct);
      #1;
      if (mon_on) begin
        if (prev_stall) begin
          check("R5 valid held", {63'd0, flit_valid}, 64'd1);
          check("R5 flit held", 64'(flit_data), 64'(prev_flit));
        end
        if (flit_valid && flit_ready) begin
          if (exp_q.size() == 0) check("R6 extra flit", 64'(flit_data), 64'd0);
          else check(tag_q.pop_front(), 64'(flit_data), 64'(exp_q.pop_front()));
        end
        prev_stall = flit_valid && !flit_ready;
        prev_flit  = flit_data;
      end
    end
  end

  task automatic send_pkt(logic [NODE_W-1:0] d, int n);
    logic [DATA_W-1:0] w[MAX_LEN];
    int i;
    for (int k = 0; k < n; k++) w[k] = $urandom;
    exp_q.push_back(mk_flit(2'b01, d, NODE_W'(MY_ID), {16'd0, exp_pnum, 8'(n)}));
    tag_q.push_back("R1 R4 header");
    exp_pnum = exp_pnum + 8'd1;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mk_flit((k == n-1) ? 2'b11 : 2'b10, d, NODE_W'(MY_ID), w[k]));
      tag_q.push_back((k == n-1) ? ((n == 1) ? "R3 end" : "R2 end") : "R2 R6 body");
    end
    @(negedge clk); #2;
    cmd_valid = 1'b1; cmd_dest = d; cmd_len = LEN_W'(n-1);
    forever begin
      if (cmd_ready) begin
        @(negedge clk); #2;
        cmd_valid = 1'b0;
        break;
      end
      @(negedge clk); #2;
    end
    check("R7 busy after accept", {63'd0, cmd_ready}, 64'd0);
    i = 0;
    while (i < n) begin
      if (($urandom % 4) == 0) wd_valid = 1'b0;
      else begin
        wd_valid = 1'b1; wd_data = w[i];
        if (wd_ready) i++;
      end
      @(negedge clk); #2;
    end
    wd_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    check("R6 all flits out", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic rx_one(logic [1:0] k, logic [NODE_W-1:0] d, logic [NODE_W-1:0] s,
                        logic [DATA_W-1:0] p, bit exp_we, logic [LEN_W-1:0] exp_idx, string req);
    @(negedge clk); #1;
    rx_valid = 1'b1; rx_flit = mk_flit(k, d, s, p);
    @(negedge clk); #1;
    rx_valid = 1'b0;
    check(req, {63'd0, mem_we}, {63'd0, exp_we});
    if (exp_we) begin
      check(req, 64'(mem_addr), 64'({s, exp_idx}));
      check(req, 64'(mem_wdata), 64'(p));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    #1;
    check("R8 flit_valid in reset", {63'd0, flit_valid}, 64'd0);
    check("R8 mem_we in reset", {63'd0, mem_we}, 64'd0);
    @(negedge clk); rst_n = 1'b1; #1;
    check("R8 cmd_ready after reset", {63'd0, cmd_ready}, 64'd1);
    check("R8 flit_valid after reset", {63'd0, flit_valid}, 64'd0);
    mon_on = 1'b1;

    // directed: single word, full length, full ready then backpressure
    send_pkt(4'd3, 1); drain();
    send_pkt(4'd9, MAX_LEN); drain();
    rdy_pct = 30;
    send_pkt(4'd0, 1); drain();
    send_pkt(4'd15, MAX_LEN); drain();

    // random lengths and backpressure; crosses the packet number wrap
    for (int p = 0; p < 300; p++) begin
      rdy_pct = 20 + ($urandom % 81);
      send_pkt(NODE_W'($urandom), (p % 5 == 0) ? 1 : 1 + int'($urandom % MAX_LEN));
    end
    drain();
    check("R4 packets counted", 64'(exp_pnum), 64'(8'(304)));

    // receive path
    rx_one(2'b01, 4'(MY_ID), 4'd2, 32'h1111_0000, 1'b0, 4'd0, "R10 header no write");
    rx_one(2'b10, 4'(MY_ID), 4'd2, 32'hAAAA_0001, 1'b1, 4'd0, "R9 first body");
    rx_one(2'b10, 4'd7,      4'd2, 32'hBAD0_0002, 1'b0, 4'd0, "R10 foreign dest");
    rx_one(2'b00, 4'(MY_ID), 4'd2, 32'hBAD0_0003, 1'b0, 4'd0, "R10 none kind");
    rx_one(2'b10, 4'(MY_ID), 4'd2, 32'hAAAA_0004, 1'b1, 4'd1, "R9 second body");
    rx_one(2'b11, 4'(MY_ID), 4'd2, 32'hAAAA_0005, 1'b1, 4'd2, "R9 end");
    rx_one(2'b01, 4'(MY_ID), 4'd11, 32'h2222_0000, 1'b0, 4'd0, "R10 header no write");
    rx_one(2'b11, 4'(MY_ID), 4'd11, 32'hCCCC_0006, 1'b1, 4'd0, "R9 index restart");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule